// File: doc/BRIEF.md
# Digital Angle Tracking Loop

This block recovers a shaft angle from a pair of demodulated resolver samples (sine and cosine of the shaft angle, signed, scaled by an unknown but steady amplitude). It keeps a 14-bit angle estimate in an up/down counter. For every accepted sample it forms the sine of the angle difference between the input and the estimate, filters that error through a proportional-plus-integral path, and turns the filtered rate into single-LSB count pulses from a phase accumulator. The result is a closed type-II loop that drives the difference to zero. The estimate therefore follows the shaft continuously, with no start command, no busy flag and no handshake.

The angle estimate is plain binary. The top bit weighs half a turn and the LSB is 360/16384 degrees. The scaled error of the most recent sample is exported as a signed word so that a neighbouring monitor can flag over-speed or loss of lock. Excitation, demodulation and the converters feeding the samples sit outside this block.

Top module: `angle_track_loop`

## Requirements
- R1: While `rst_ni` is low and after its release, `angle_o` is 0 and `err_o` is 0 until the first sample with `valid_i` high.
- R2: `angle_o` is an unsigned binary fraction of a turn: value v stands for v*360/16384 degrees. It wraps modulo 16384 in both directions, so 0 steps down to 16383 and 16383 steps up to 0.
- R3: At each clock edge with `valid_i` high, `err_o` becomes floor((`sin_i`*C - `cos_i`*S)/1024). S and C are the table sine and cosine of the angle held before that edge, with full scale 4095 (at angle 0, S=0 and C=4095). Examples: sin=2047, cos=0 gives 8186; sin=-2047, cos=0 gives -8187; sin=1000, cos=-500 gives 3999.
- R4: On edges with `valid_i` low, `angle_o` and `err_o` keep their values whatever `sin_i` and `cos_i` do.
- R5: `angle_o` changes by at most one LSB per valid sample. A positive error steps it up: from reset with a 90 degree input, it reads 0 after one valid sample, 1 after two, and 9 after ten.
- R6: With a constant full-scale input held and `valid_i` high every cycle, `angle_o` settles within 12 LSB of the input angle in any quadrant within 12000 samples. A zero-angle input leaves it at 0.
- R7: The estimate moves along the shorter arc. Moving from 350 degrees to 5 degrees, it passes through the wrap point and never enters the range 1001 to 14999.
- R8: For an input angle that advances one LSB every four samples, `angle_o` stays within 12 LSB of the input once the loop has locked, with no growing lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; one loop update per high cycle |
| sin_i | input | 12 | Signed sine sample of the shaft angle |
| cos_i | input | 12 | Signed cosine sample of the shaft angle |
| angle_o | output | 14 | Tracked angle, LSB = 360/16384 degrees |
| err_o | output | 16 | Signed scaled error of the last sample |

## Verification
Single samples against a freshly reset estimate pin down the error arithmetic. A pure sine, a negated sine and a mixed-sign pair separate a wrong product term, a swapped subtraction and truncation toward zero instead of flooring. Static angles in the first, third and fourth quadrants show that the table folding and the step direction are right everywhere on the circle. A move across zero catches a loop that takes the long way round, and a zero-angle input exposes any bias or drift. A slow ramp separates a true type-II loop from one that only nulls a static error. A strobe-low interval with changing inputs shows that nothing advances without a sample.

// File: rtl/angle_track_pkg.sv
package angle_track_pkg;
  localparam real PI = 3.14159265358979323846;
  localparam int DEF_ANG_W  = 14;
  localparam int DEF_SAMP_W = 12;
  localparam int DEF_LUT_AW = 10;
  localparam int DEF_LUT_W  = 12;
endpackage

// File: rtl/trig_lut.sv
module trig_lut
  import angle_track_pkg::*;
#(
  parameter int LUT_AW = DEF_LUT_AW,
  parameter int LUT_W  = DEF_LUT_W
) (
  input  logic [LUT_AW+1:0]       phase_i,
  output logic signed [LUT_W:0]   sin_o,
  output logic signed [LUT_W:0]   cos_o
);
  localparam int  N   = 1 << LUT_AW;
  localparam real AMP = real'((1 << LUT_W) - 1);

  // quarter wave, N+1 points so that 90 degrees is exact
  logic [LUT_W-1:0] rom [N+1];
  for (genvar g = 0; g <= N; g++) begin : g_rom
    localparam int V = int'($floor(AMP * $sin(PI * real'(g) / real'(2 * N)) + 0.5));
    assign rom[g] = LUT_W'(V);
  end

  logic [1:0]        quad;
  logic [LUT_AW:0]   idx, rev, a_s, a_c;
  logic              n_s, n_c;
  logic signed [LUT_W:0] m_s, m_c;

  assign quad = phase_i[LUT_AW+1:LUT_AW];
  assign idx  = {1'b0, phase_i[LUT_AW-1:0]};
  assign rev  = (LUT_AW+1)'(N) - idx;

  always_comb begin
    a_s = quad[0] ? rev : idx;
    a_c = quad[0] ? idx : rev;
    n_s = quad[1];
    n_c = quad[1] ^ quad[0];
  end

  assign m_s   = signed'({1'b0, rom[a_s]});
  assign m_c   = signed'({1'b0, rom[a_c]});
  assign sin_o = n_s ? -m_s : m_s;
  assign cos_o = n_c ? -m_c : m_c;
endmodule

// File: rtl/err_detect.sv
module err_detect
  import angle_track_pkg::*;
#(
  parameter int SAMP_W    = DEF_SAMP_W,
  parameter int LUT_W     = DEF_LUT_W,
  parameter int ERR_SHIFT = 10,
  parameter int ERR_W     = SAMP_W + LUT_W + 2 - ERR_SHIFT
) (
  input  logic signed [SAMP_W-1:0] sin_i,
  input  logic signed [SAMP_W-1:0] cos_i,
  input  logic signed [LUT_W:0]    lut_sin_i,
  input  logic signed [LUT_W:0]    lut_cos_i,
  output logic signed [ERR_W-1:0]  err_o
);
  localparam int PROD_W = SAMP_W + LUT_W + 1;
  localparam int DIFF_W = PROD_W + 1;

  logic signed [PROD_W-1:0] p_sc, p_cs;
  logic signed [DIFF_W-1:0] diff;

  assign p_sc  = PROD_W'(sin_i * lut_cos_i);
  assign p_cs  = PROD_W'(cos_i * lut_sin_i);
  assign diff  = DIFF_W'(p_sc) - DIFF_W'(p_cs);
  // arithmetic shift floors toward minus infinity
  assign err_o = ERR_W'(diff >>> ERR_SHIFT);
endmodule

// File: rtl/loop_filter.sv
module loop_filter #(
  parameter int ERR_W   = 16,
  parameter int INT_W   = 20,
  parameter int P_SHIFT = 10,
  parameter int I_SHIFT = 5,
  parameter int PH_W    = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic [PH_W-1:0]         inc_o,
  output logic                    down_o
);
  localparam int P_W    = ERR_W + P_SHIFT;
  localparam int I_W    = INT_W + I_SHIFT;
  localparam int RATE_W = ((P_W > I_W) ? P_W : I_W) + 1;
  localparam logic signed [INT_W-1:0] ACC_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W-1:0] ACC_MIN = {1'b1, {(INT_W-1){1'b0}}};

  logic signed [INT_W-1:0]  acc_q, acc_nxt;
  logic signed [ERR_W-1:0]  err_q;
  logic signed [INT_W:0]    sum;
  logic signed [RATE_W-1:0] rate;
  logic [RATE_W-1:0]        mag;
  logic                     clip;

  assign rate   = (RATE_W'(err_i) <<< P_SHIFT) + (RATE_W'(acc_q) <<< I_SHIFT);
  assign mag    = rate[RATE_W-1] ? $unsigned(-rate) : $unsigned(rate);
  assign clip   = |mag[RATE_W-1:PH_W];
  assign inc_o  = clip ? '1 : mag[PH_W-1:0];
  assign down_o = rate[RATE_W-1];

  assign sum = (INT_W+1)'(acc_q) + (INT_W+1)'(err_i);
  always_comb begin
    if (sum[INT_W] != sum[INT_W-1]) acc_nxt = sum[INT_W] ? ACC_MIN : ACC_MAX;
    else                            acc_nxt = sum[INT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      err_q <= '0;
    end else if (valid_i) begin
      err_q <= err_i;
      // hold the integrator while the rate is clipped (anti-windup)
      if (!clip) acc_q <= acc_nxt;
    end
  end

  assign err_o = err_q;

  assert_err_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(err_q));
  assert_int_hi_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q > (ACC_MAX >>> 1)) |=> !acc_q[INT_W-1]);
  assert_int_lo_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q < (ACC_MIN >>> 1)) |=> acc_q[INT_W-1]);
  assert_int_frozen_clip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && inc_o == '1 && clip) |=> $stable(acc_q));
endmodule

// File: rtl/rate_nco.sv
module rate_nco #(
  parameter int PH_W  = 16,
  parameter int ANG_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PH_W-1:0]  inc_i,
  input  logic             down_i,
  output logic [ANG_W-1:0] angle_o
);
  logic [PH_W-1:0]  ph_q;
  logic [PH_W:0]    ph_sum;
  logic [ANG_W-1:0] cnt_q;

  assign ph_sum = {1'b0, ph_q} + {1'b0, inc_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      cnt_q <= '0;
    end else if (valid_i) begin
      ph_q <= ph_sum[PH_W-1:0];
      if (ph_sum[PH_W]) cnt_q <= down_i ? cnt_q - ANG_W'(1) : cnt_q + ANG_W'(1);
    end
  end

  assign angle_o = cnt_q;

  assert_one_lsb_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ANG_W'(1)
              || cnt_q == $past(cnt_q) - ANG_W'(1)));
  assert_angle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
  assert_wrap_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ph_sum[PH_W] && down_i && cnt_q == '0) |=> cnt_q == '1);
  assert_wrap_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ph_sum[PH_W] && !down_i && cnt_q == '1) |=> cnt_q == '0);
endmodule

// File: rtl/angle_track_loop.sv
module angle_track_loop
  import angle_track_pkg::*;
#(
  parameter int ANG_W     = DEF_ANG_W,
  parameter int SAMP_W    = DEF_SAMP_W,
  parameter int LUT_AW    = DEF_LUT_AW,
  parameter int LUT_W     = DEF_LUT_W,
  parameter int ERR_SHIFT = 10,
  parameter int INT_W     = 20,
  parameter int P_SHIFT   = 10,
  parameter int I_SHIFT   = 5,
  parameter int PH_W      = 16,
  localparam int ERR_W    = SAMP_W + LUT_W + 2 - ERR_SHIFT
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [SAMP_W-1:0] sin_i,
  input  logic signed [SAMP_W-1:0] cos_i,
  output logic [ANG_W-1:0]         angle_o,
  output logic signed [ERR_W-1:0]  err_o
);
  logic signed [LUT_W:0]   lut_sin, lut_cos;
  logic signed [ERR_W-1:0] err_now;
  logic [PH_W-1:0]         inc;
  logic                    down;

  trig_lut #(.LUT_AW(LUT_AW), .LUT_W(LUT_W)) i_trig_lut (
    .phase_i (angle_o[ANG_W-1 -: LUT_AW+2]),
    .sin_o   (lut_sin),
    .cos_o   (lut_cos)
  );

  err_detect #(.SAMP_W(SAMP_W), .LUT_W(LUT_W), .ERR_SHIFT(ERR_SHIFT), .ERR_W(ERR_W)) i_err_detect (
    .sin_i     (sin_i),
    .cos_i     (cos_i),
    .lut_sin_i (lut_sin),
    .lut_cos_i (lut_cos),
    .err_o     (err_now)
  );

  loop_filter #(.ERR_W(ERR_W), .INT_W(INT_W), .P_SHIFT(P_SHIFT), .I_SHIFT(I_SHIFT), .PH_W(PH_W)) i_loop_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .err_i   (err_now),
    .err_o   (err_o),
    .inc_o   (inc),
    .down_o  (down)
  );

  rate_nco #(.PH_W(PH_W), .ANG_W(ANG_W)) i_rate_nco (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .inc_i   (inc),
    .down_i  (down),
    .angle_o (angle_o)
  );

  assert_reset_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_ni) && !valid_i) |-> (angle_o == '0 && err_o == '0));
endmodule

// File: tb/test_angle_track_loop.sv
module test_angle_track_loop;
  localparam int  FULL = 16384;
  localparam int  TOL  = 12;
  localparam real AMP  = 2047.0;
  localparam real TWO_PI = 6.28318530717958647692;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic signed [11:0] sin_i = '0;
  logic signed [11:0] cos_i = '0;
  logic [13:0]        angle_o;
  logic signed [15:0] err_o;

  int errors = 0;
  int checks = 0;

  always #4 clk_i = ~clk_i;

  angle_track_loop i_angle_track_loop (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .sin_i(sin_i), .cos_i(cos_i), .angle_o(angle_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mdist(input int a, input int b);
    int d = (a - b) % FULL;
    if (d < 0) d += FULL;
    if (d > FULL / 2) d = FULL - d;
    return d;
  endfunction

  task automatic set_angle(input real lsb);
    real ph = TWO_PI * lsb / real'(FULL);
    sin_i = 12'($rtoi($floor(AMP * $sin(ph) + 0.5)));
    cos_i = 12'($rtoi($floor(AMP * $cos(ph) + 0.5)));
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic one_sample(input int s, input int c);
    sin_i = 12'(s);
    cos_i = 12'(c);
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check(angle_o == 14'd0, "R1", "angle after reset", angle_o, 0);
    check(err_o == 16'sd0, "R1", "err after reset", err_o, 0);
  endtask

  task automatic t_err_math();
    do_reset();
    one_sample(2047, 0);
    check(err_o == 16'sd8186, "R3", "err 90deg", err_o, 8186);
    do_reset();
    one_sample(-2047, 0);
    check(err_o == -16'sd8187, "R3", "err 270deg floor", err_o, -8187);
    do_reset();
    one_sample(1000, -500);
    check(err_o == 16'sd3999, "R3", "err mixed", err_o, 3999);
  endtask

  task automatic t_first_steps();
    do_reset();
    sin_i = 12'sd2047;
    cos_i = 12'sd0;
    valid_i = 1'b1;
    @(negedge clk_i);
    check(angle_o == 14'd0, "R5", "angle after 1 sample", angle_o, 0);
    @(negedge clk_i);
    check(angle_o == 14'd1, "R5", "angle after 2 samples", angle_o, 1);
    repeat (8) @(negedge clk_i);
    check(angle_o == 14'd9, "R5", "angle after 10 samples", angle_o, 9);
    valid_i = 1'b0;
  endtask

  task automatic t_zero_input();
    do_reset();
    set_angle(0.0);
    valid_i = 1'b1;
    repeat (20) @(negedge clk_i);
    valid_i = 1'b0;
    check(angle_o == 14'd0, "R6", "zero input angle", angle_o, 0);
    check(err_o == 16'sd0, "R6", "zero input err", err_o, 0);
  endtask

  task automatic t_converge(input int target, input int cycles);
    set_angle(real'(target));
    valid_i = 1'b1;
    repeat (cycles) @(negedge clk_i);
    check(mdist(int'(angle_o), target) <= TOL, "R6", "static settle", angle_o, target);
  endtask

  task automatic t_hold();
    logic [13:0]        a0;
    logic signed [15:0] e0;
    valid_i = 1'b0;
    @(negedge clk_i);
    a0 = angle_o;
    e0 = err_o;
    for (int k = 0; k < 50; k++) begin
      set_angle(real'(12288 + 97 * k));
      @(negedge clk_i);
    end
    check(angle_o == a0, "R4", "angle held without strobe", angle_o, a0);
    check(err_o == e0, "R4", "err held without strobe", err_o, e0);
  endtask

  task automatic t_wrap();
    int bad = 0;
    int worst = 0;
    t_converge(15929, 12000);
    set_angle(228.0);
    valid_i = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk_i);
      if (angle_o > 14'd1000 && angle_o < 14'd15000) begin
        bad++;
        worst = int'(angle_o);
      end
    end
    check(bad == 0, "R7", "short arc across zero (R2 wrap)", worst, 0);
    check(mdist(int'(angle_o), 228) <= TOL, "R2", "settle after wrap", angle_o, 228);
  endtask

  task automatic t_ramp();
    int pos = 228;
    int worst = 0;
    int worst_a = 0;
    valid_i = 1'b1;
    for (int k = 0; k < 8000; k++) begin
      if (k % 4 == 0) pos = (pos + 1) % FULL;
      set_angle(real'(pos));
      @(negedge clk_i);
      if (k >= 6000 && mdist(int'(angle_o), pos) > worst) begin
        worst = mdist(int'(angle_o), pos);
        worst_a = int'(angle_o);
      end
    end
    check(worst <= TOL, "R8", "ramp lag", worst_a, pos);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog all requirements: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_err_math();
    t_first_steps();
    t_zero_input();
    do_reset();
    t_converge(2048, 12000);
    t_hold();
    t_converge(9102, 12000);
    t_wrap();
    t_ramp();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule